// File: doc/BRIEF.md
# Instrument Status Reporting Registers

This block holds the status state that a remotely programmed instrument reports to its host. There is an 8-bit event register whose bits latch single-cycle event pulses from the rest of the instrument, with an 8-bit enable mask for it. There is also a status byte that is built live from device status inputs, the masked event summary, and a service request bit, with its own 8-bit enable mask.

The host uses one request port. Each request carries a 3-bit operation code and write data. Read results come back on a registered data bus one cycle later, flagged by a valid strobe. Bit 6 of the status byte has two views. The master summary view is recomputed every cycle and is never cleared by a read. The request view latches on a rising edge of that summary and is cleared only by a serial poll or a clear command. The request view also drives the service request output.

Top module: `stat_report`

## Requirements
- R1: After reset the event register holds 0x80, which is the power-on bit (bit 7). Both enable masks read 0. `srq` is low.
- R2: Each high bit of `ev_set` sets the same bit of the event register. The bit stays set until the event register is read or a clear is issued.
- R3: Op code 4 returns the event register and then empties it, so an immediate second read returns 0. An `ev_set` pulse in the same cycle as the read is kept in the new value.
- R4: Op code 0 writes the event enable mask. Op code 2 reads back the full 8 bits last written; for example, 60 enables bits 5, 4, 3 and 2.
- R5: Op code 1 writes the service request enable mask. Op code 3 reads it back, with bit 6 always 0 whatever was written.
- R6: Status byte bit 5 is 1 when the event register ANDed with its enable mask is nonzero. Bit 3 follows `dev_stat[3]`, the questionable summary. Bits 7, 4, 2, 1 and 0 follow `dev_stat`. `dev_stat[6:5]` is ignored.
- R7: `mss` is 1 when the status byte (bit 6 excluded) ANDed with the request enable mask is nonzero. Op code 5 returns the status byte with bit 6 equal to `mss`, and clears nothing.
- R8: `srq` rises in the cycle after a clock edge at which `mss` is 1 and was 0 at the previous edge.
- R9: Op code 7 (serial poll) returns the status byte with bit 6 equal to `srq`, then clears `srq`. While `mss` stays high, `srq` is not set again. A new rising edge of `mss` sets it again, and that set takes priority over a poll in the same cycle.
- R10: Op code 6 empties the event register, keeping same-cycle pulses, and clears `srq`. Both masks are kept.
- R11: Op codes 2, 3, 4, 5 and 7 are reads. A read raises `host_rvalid` for one cycle after the edge that accepts it, with `host_rdata` valid. Other op codes and idle cycles leave `host_rvalid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ev_set | input | 8 | Single-cycle event pulses, one per event bit |
| dev_stat | input | 8 | Live device status bits for the status byte; bits 6 and 5 unused |
| host_req | input | 1 | Host request strobe |
| host_op | input | 3 | Operation code |
| host_wdata | input | 8 | Mask write data |
| host_rdata | output | 8 | Registered read data |
| host_rvalid | output | 1 | Read data valid, one cycle after a read request |
| srq | output | 1 | Service request (request view of bit 6) |
| mss | output | 1 | Live master summary (summary view of bit 6) |

## Verification
The properties take `ev_set` and `dev_stat` to be stable across each clock edge. They treat `mss` as a combinational function of registered state and those inputs, so its rise is seen exactly once per edge. The stimulus drives every input only at the falling edge. It holds `dev_stat` for random stretches so that rising and persisting summaries both occur. It keeps event pulses sparse so that destructive reads see both empty and populated registers.

// File: rtl/stat_report.sv
module stat_report #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] ev_set,
  input  logic [DW-1:0] dev_stat,
  input  logic          host_req,
  input  logic [2:0]    host_op,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          host_rvalid,
  output logic          srq,
  output logic          mss
);
  localparam int PON_BIT = DW - 1;
  localparam int SUM_BIT = 6;
  localparam int ESB_BIT = 5;
  localparam logic [DW-1:0] SUM_MASK = DW'(1) << SUM_BIT;
  localparam logic [DW-1:0] PON_VAL  = DW'(1) << PON_BIT;

  localparam logic [2:0] OP_WR_ESE = 3'd0;
  localparam logic [2:0] OP_WR_SRE = 3'd1;
  localparam logic [2:0] OP_RD_ESE = 3'd2;
  localparam logic [2:0] OP_RD_SRE = 3'd3;
  localparam logic [2:0] OP_RD_ESR = 3'd4;
  localparam logic [2:0] OP_RD_STB = 3'd5;
  localparam logic [2:0] OP_CLEAR  = 3'd6;
  localparam logic [2:0] OP_POLL   = 3'd7;

  logic [DW-1:0] esr, ese, sre, stb_base, rd_val;
  logic          esb, mss_q, rise, is_read;

  wire do_poll  = host_req && host_op == OP_POLL;
  wire do_clear = host_req && host_op == OP_CLEAR;
  wire esr_wipe = host_req && (host_op == OP_RD_ESR || host_op == OP_CLEAR);

  assign esb  = |(esr & ese);
  assign rise = mss && !mss_q;
  assign mss  = |(stb_base & sre & ~SUM_MASK);

  always_comb begin
    stb_base = dev_stat & ~SUM_MASK;
    stb_base[ESB_BIT] = esb;
  end

  always_comb begin
    is_read = 1'b1;
    rd_val  = '0;
    case (host_op)
      OP_RD_ESE: rd_val = ese;
      OP_RD_SRE: rd_val = sre;
      OP_RD_ESR: rd_val = esr;
      OP_RD_STB: rd_val = stb_base | (mss ? SUM_MASK : '0);
      OP_POLL:   rd_val = stb_base | (srq ? SUM_MASK : '0);
      default:   is_read = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      esr   <= PON_VAL;
      ese   <= '0;
      sre   <= '0;
      mss_q <= 1'b0;
      srq   <= 1'b0;
    end else begin
      esr   <= (esr_wipe ? '0 : esr) | ev_set;
      mss_q <= mss;
      if (host_req && host_op == OP_WR_ESE) ese <= host_wdata;
      if (host_req && host_op == OP_WR_SRE) sre <= host_wdata & ~SUM_MASK;
      if (rise) srq <= 1'b1;
      else if (do_poll || do_clear) srq <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
    end else begin
      host_rvalid <= host_req && is_read;
      if (host_req && is_read) host_rdata <= rd_val;
    end
  end
endmodule

module stat_report_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] ev_set,
  input logic       host_req,
  input logic [2:0] host_op,
  input logic [7:0] host_rdata,
  input logic       host_rvalid,
  input logic       srq,
  input logic       mss,
  input logic [7:0] esr
);
  // R2
  ev_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((esr & $past(ev_set)) == $past(ev_set)));
  // R3
  esr_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_op == 3'd4 && ev_set == 8'd0) |=> (esr == 8'd0));
  // R5
  sre_bit6_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_op == 3'd3) |=> !host_rdata[6]);
  // R8
  srq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mss) |=> srq);
  // R9
  poll_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_op == 3'd7 && !$rose(mss)) |=> !srq);
  // R9
  no_reassert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!srq && !$rose(mss)) |=> !srq);
  // R11
  rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_op inside {3'd2, 3'd3, 3'd4, 3'd5, 3'd7}) |=> host_rvalid);
  // R11
  rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_req && host_op inside {3'd2, 3'd3, 3'd4, 3'd5, 3'd7}) |=> !host_rvalid);
endmodule

bind stat_report stat_report_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev_set(ev_set), .host_req(host_req),
  .host_op(host_op), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
  .srq(srq), .mss(mss), .esr(esr)
);

// File: tb/stat_report_bench.sv
module stat_report_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ev_set = '0, dev_stat = '0, host_wdata = '0;
  logic       host_req = 1'b0;
  logic [2:0] host_op = '0;
  logic [7:0] host_rdata;
  logic       host_rvalid, srq, mss;

  int errors = 0, checks = 0;
  logic [7:0] m_esr = 8'h80, m_ese = '0, m_sre = '0;
  logic       m_srq = 1'b0, m_mssq = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stat_report u_stat_report (
    .clk(clk), .rst_n(rst_n), .ev_set(ev_set), .dev_stat(dev_stat),
    .host_req(host_req), .host_op(host_op), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid), .srq(srq), .mss(mss)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] f_stb(input logic [7:0] esr, ese, dev);
    logic [7:0] s;
    s = dev & 8'hBF;
    s[5] = |(esr & ese);
    return s;
  endfunction

  function automatic logic f_mss(input logic [7:0] stb, sre);
    return |(stb & sre & 8'hBF);
  endfunction

  task automatic cyc(input logic req, input logic [2:0] op, input logic [7:0] wd,
                     input logic [7:0] ev, input logic [7:0] dev, input string tag);
    logic [7:0] stb, exp_rd;
    logic m, rd, rise;
    @(negedge clk);
    host_req = req; host_op = op; host_wdata = wd; ev_set = ev; dev_stat = dev;
    #1;
    stb = f_stb(m_esr, m_ese, dev);
    m = f_mss(stb, m_sre);
    check({"R7 mss ", tag}, {7'd0, mss}, {7'd0, m});
    rd = req && (op inside {3'd2, 3'd3, 3'd4, 3'd5, 3'd7});
    case (op)
      3'd2: exp_rd = m_ese;
      3'd3: exp_rd = m_sre;
      3'd4: exp_rd = m_esr;
      3'd5: exp_rd = stb | {1'b0, m, 6'd0};
      3'd7: exp_rd = stb | {1'b0, m_srq, 6'd0};
      default: exp_rd = '0;
    endcase
    rise = m && !m_mssq;
    m_esr = ((req && (op == 3'd4 || op == 3'd6)) ? 8'd0 : m_esr) | ev;
    if (req && op == 3'd0) m_ese = wd;
    if (req && op == 3'd1) m_sre = wd & 8'hBF;
    if (rise) m_srq = 1'b1;
    else if (req && (op == 3'd7 || op == 3'd6)) m_srq = 1'b0;
    m_mssq = m;
    @(posedge clk);
    #1;
    check({"R11 rvalid ", tag}, {7'd0, host_rvalid}, {7'd0, rd});
    if (rd) check({"R3/R4/R5/R6/R7/R9 rdata ", tag}, host_rdata, exp_rd);
    check({"R8/R9/R10 srq ", tag}, {7'd0, srq}, {7'd0, m_srq});
  endtask

  initial begin
    #(CLK_PERIOD * 250000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] dv;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 srq at reset", {7'd0, srq}, 8'd0);
    rst_n = 1'b1;
    cyc(1, 3'd2, 0, 0, 0, "R1 ese reset");
    cyc(1, 3'd3, 0, 0, 0, "R1 sre reset");
    cyc(1, 3'd4, 0, 0, 0, "R1 R3 pon read");
    cyc(1, 3'd4, 0, 0, 0, "R3 second read zero");
    cyc(1, 3'd0, 8'd60, 0, 0, "R4 write 60");
    cyc(1, 3'd2, 0, 0, 0, "R4 readback 60");
    cyc(1, 3'd1, 8'hFF, 0, 0, "R5 write ff");
    cyc(1, 3'd3, 0, 0, 0, "R5 bit6 zero");
    cyc(1, 3'd1, 8'd40, 0, 0, "R5 write 40");
    cyc(0, 3'd0, 0, 8'h20, 0, "R2 cmd error pulse");
    cyc(1, 3'd5, 0, 0, 0, "R6 R7 stb esb");
    cyc(1, 3'd5, 0, 0, 0, "R7 stb no clear");
    cyc(1, 3'd7, 0, 0, 0, "R9 poll");
    cyc(1, 3'd7, 0, 0, 0, "R9 no reassert");
    cyc(1, 3'd4, 0, 8'h10, 0, "R3 pulse survives read");
    cyc(1, 3'd4, 0, 0, 0, "R3 survivor read");
    cyc(0, 3'd0, 0, 0, 8'h08, "R6 ques rise");
    cyc(1, 3'd6, 0, 8'h01, 8'h08, "R10 clear");
    cyc(1, 3'd2, 0, 0, 8'h08, "R10 mask kept");
    cyc(1, 3'd4, 0, 0, 0, "R10 pulse kept");
    cyc(1, 3'd5, 0, 0, 8'hFF, "R6 dev bits");
    dv = '0;
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] ev;
      if ($urandom_range(0, 7) == 0) dv = 8'($urandom);
      ev = ($urandom_range(0, 5) == 0) ? (8'd1 << $urandom_range(0, 7)) : 8'd0;
      cyc($urandom_range(0, 2) != 0, 3'($urandom), 8'($urandom), ev, dv, "random");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule